// File: doc/BRIEF.md
# Unified Second-Level Victim Cache

This block is a second-level cache that takes in only lines pushed out of the first-level instruction and data caches. A first-level miss probes it. On a hit the line goes back to the first level and is removed here, so a line lives in only one of the two levels at a time. A two-bit mode input sets which kind of victim, instruction or data, may be allocated.

The block keeps tag, valid, dirty and an instruction/data flag for each way. It has three interfaces. The eviction input takes one line per cycle. The probe port returns its response two cycles after the request. The write-back output carries dirty lines that the block pushes out, and dirty victims that it refuses to store. Addresses on every port are line addresses: the byte address with the line-offset bits removed. The low `SET_W` bits of an address select the set and the remaining bits form the tag. The default geometry is 64 sets of 4 ways with 32-byte lines.

Top module: `l2_victim_cache`

## Requirements
- R1: After `rst_ni` is released, every line is invalid. `resp_valid_o` and `wb_valid_o` are 0, and any probe misses.
- R2: A probe sampled at clock edge k gives `resp_valid_o`=1 after edge k+1, and not earlier. On a hit the response carries the stored data, dirty flag and instruction flag.
- R3: A probe hit invalidates the line, so a second probe to the same address misses.
- R4: A probe miss returns `resp_hit_o`=0 with `resp_dirty_o`=0 and `resp_instr_o`=0.
- R5: `mode_i[0]`=1 allows data victims (`evict_instr_i`=0), and `mode_i[1]`=1 allows instruction victims. A victim of a disallowed kind is not stored. If it is dirty, it appears on the write-back port after the next edge with its own address and data. If it is clean, it is dropped.
- R6: Four lines with distinct tags in one set are all held at the same time.
- R7: An allocation fills the lowest-numbered invalid way first. When the set is full, a 3-bit tree pseudo-LRU picks the way:
  - Root bit b0=0 selects way 0 or 1 by b1; b0=1 selects way 2 or 3 by b2. A bit value of 0 selects the lower way of the pair.
  - Each allocation points the bits away from the way it wrote.
  - Filling ways 0 to 3 in order and then allocating twice replaces way 0 and then way 2.
- R8: A displaced valid dirty line is presented on `wb_valid_o`/`wb_addr_o`/`wb_data_o` for one cycle after the edge that sampled the eviction. A displaced clean line produces no write-back.
- R9: An eviction and a probe to the same address in one cycle are handled probe first. The probe returns the old copy, and afterwards the cache holds the evicted data.
- R10: An allowed eviction to an address already present overwrites that line in place without a write-back. The line's dirty flag becomes the OR of the old flag and the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Allocation enable: bit0 data, bit1 instruction |
| evict_valid_i | input | 1 | Eviction request |
| evict_addr_i | input | 27 | Line address of the victim |
| evict_data_i | input | 256 | Victim line data |
| evict_dirty_i | input | 1 | Victim is modified |
| evict_instr_i | input | 1 | Victim came from the instruction cache |
| probe_valid_i | input | 1 | Probe request |
| probe_addr_i | input | 27 | Line address probed |
| resp_valid_o | output | 1 | Probe response valid (two cycles after request) |
| resp_hit_o | output | 1 | Probe hit |
| resp_data_o | output | 256 | Returned line |
| resp_dirty_o | output | 1 | Returned line is modified |
| resp_instr_o | output | 1 | Returned line is an instruction line |
| wb_valid_o | output | 1 | Write-back to memory valid |
| wb_addr_o | output | 27 | Write-back line address |
| wb_data_o | output | 256 | Write-back line data |

## Verification
The bench fills one set to capacity and then allocates twice. This shows that the tree replacement removes way 0 and then way 2. A true-LRU or round-robin design would instead lose the second-oldest line or keep the first. The test also checks that only the dirty victim is written out; a design that writes back clean victims, or never writes back, fails here. Both disallowed cases of the mode filter are covered: a dirty victim must leak to the write-back port, and a clean victim must leave no trace. A design that stores filtered lines is caught by a later probe hit. The bench also drives a probe and an eviction to the same address in one cycle, and an eviction that overwrites a resident line. A wrong ordering returns the new data too early, leaves a duplicate way, or drops the dirty flag.

// File: rtl/l2v_pkg.sv
package l2v_pkg;
  localparam int WAYS = 4;  // tree replacement below is built for four ways
  typedef logic [2:0] plru_t;

  function automatic logic [1:0] plru_victim(plru_t b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  function automatic plru_t plru_touch(plru_t b, logic [1:0] w);
    plru_t n;
    n = b;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/l2v_plru.sv
module l2v_plru
  import l2v_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] q_set_i,
  output logic [1:0]       victim_o,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [1:0]       touch_way_i
);
  plru_t bits_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
    end else if (touch_en_i) begin
      bits_q[touch_set_i] <= plru_touch(bits_q[touch_set_i], touch_way_i);
    end
  end

  assign victim_o = plru_victim(bits_q[q_set_i]);

  // R7: a just-written way is never the next victim of its set
  assert_touch_away_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_en_i |=> (q_set_i != $past(touch_set_i)) || (victim_o != $past(touch_way_i)));
endmodule

// File: rtl/l2v_tag_store.sv
module l2v_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SET_W-1:0]           p_set_i,
  input  logic [TAG_W-1:0]           p_tag_i,
  output logic [WAYS-1:0]            p_hit_o,
  output logic [WAYS-1:0]            p_dirty_o,
  output logic [WAYS-1:0]            p_instr_o,
  input  logic [SET_W-1:0]           e_set_i,
  input  logic [TAG_W-1:0]           e_tag_i,
  output logic [WAYS-1:0]            e_hit_o,
  output logic [WAYS-1:0]            e_valid_o,
  output logic [WAYS-1:0]            e_dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0] e_tags_o,
  input  logic                       inv_a_en_i,
  input  logic [SET_W-1:0]           inv_a_set_i,
  input  logic [WAY_W-1:0]           inv_a_way_i,
  input  logic                       inv_b_en_i,
  input  logic [SET_W-1:0]           inv_b_set_i,
  input  logic [WAY_W-1:0]           inv_b_way_i,
  input  logic                       wr_en_i,
  input  logic [SET_W-1:0]           wr_set_i,
  input  logic [WAY_W-1:0]           wr_way_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic                       wr_dirty_i,
  input  logic                       wr_instr_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  instr_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign p_hit_o[w]  = valid_q[p_set_i][w] && (tag_q[p_set_i][w] == p_tag_i);
    assign e_hit_o[w]  = valid_q[e_set_i][w] && (tag_q[e_set_i][w] == e_tag_i);
    assign e_tags_o[w] = tag_q[e_set_i][w];
  end
  assign p_dirty_o = dirty_q[p_set_i];
  assign p_instr_o = instr_q[p_set_i];
  assign e_valid_o = valid_q[e_set_i];
  assign e_dirty_o = dirty_q[e_set_i];

  // invalidations first, a write in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        instr_q[s] <= '0;
      end
    end else begin
      if (inv_a_en_i) valid_q[inv_a_set_i][inv_a_way_i] <= 1'b0;
      if (inv_b_en_i) valid_q[inv_b_set_i][inv_b_way_i] <= 1'b0;
      if (wr_en_i) begin
        valid_q[wr_set_i][wr_way_i] <= 1'b1;
        dirty_q[wr_set_i][wr_way_i] <= wr_dirty_i;
        instr_q[wr_set_i][wr_way_i] <= wr_instr_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
  end

  // R6: a line address is held in at most one way
  assert_single_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p_hit_o) && $onehot0(e_hit_o));
endmodule

// File: rtl/l2v_data_store.sv
module l2v_data_store #(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int LINE_W = 256,
  parameter int SET_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic [SET_W-1:0]  a_set_i,
  input  logic [WAY_W-1:0]  a_way_i,
  output logic [LINE_W-1:0] a_data_o,
  input  logic [SET_W-1:0]  b_set_i,
  input  logic [WAY_W-1:0]  b_way_i,
  output logic [LINE_W-1:0] b_data_o,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [LINE_W-1:0] wr_data_i
);
  logic [LINE_W-1:0] mem_q [SETS*WAYS];

  assign a_data_o = mem_q[{a_set_i, a_way_i}];
  assign b_data_o = mem_q[{b_set_i, b_way_i}];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_set_i, wr_way_i}] <= wr_data_i;
  end
endmodule

// File: rtl/l2_victim_cache.sv
module l2_victim_cache
  import l2v_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int SET_W     = $clog2(SETS),
  localparam int TAG_W     = LA_W - SET_W,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              evict_valid_i,
  input  logic [LA_W-1:0]   evict_addr_i,
  input  logic [LINE_W-1:0] evict_data_i,
  input  logic              evict_dirty_i,
  input  logic              evict_instr_i,
  input  logic              probe_valid_i,
  input  logic [LA_W-1:0]   probe_addr_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [LINE_W-1:0] resp_data_o,
  output logic              resp_dirty_o,
  output logic              resp_instr_o,
  output logic              wb_valid_o,
  output logic [LA_W-1:0]   wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o
);
  logic [SET_W-1:0] p_set, e_set;
  logic [TAG_W-1:0] p_tag, e_tag;
  assign p_set = probe_addr_i[SET_W-1:0];
  assign p_tag = probe_addr_i[LA_W-1:SET_W];
  assign e_set = evict_addr_i[SET_W-1:0];
  assign e_tag = evict_addr_i[LA_W-1:SET_W];

  logic [WAYS-1:0] p_hit, p_dirty, p_instr, e_hit, e_valid, e_dirty;
  logic [WAYS-1:0][TAG_W-1:0] e_tags;
  logic [WAYS-1:0] taken, match, free;
  logic [WAY_W-1:0] p_way, m_way, f_way, tgt_way;
  logic [1:0] v_way;
  logic p_hit_any, allow;
  logic wr_en, wr_dirty, inv_b;
  logic wb_set;
  logic [LA_W-1:0] wb_addr_d;
  logic [LINE_W-1:0] wb_data_d, p_rdata, v_rdata;

  assign p_hit_any = probe_valid_i && (|p_hit);
  assign allow     = evict_instr_i ? mode_i[1] : mode_i[0];
  // a way the probe hands back this cycle counts as free for the eviction
  assign taken     = (p_hit_any && (p_set == e_set)) ? p_hit : '0;
  assign match     = e_hit & ~taken;
  assign free      = ~e_valid | taken;

  always_comb begin
    p_way = '0;
    m_way = '0;
    f_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (p_hit[w]) p_way = WAY_W'(w);
      if (match[w]) m_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) if (free[w]) f_way = WAY_W'(w);
  end

  always_comb begin
    wr_en     = 1'b0;
    wr_dirty  = evict_dirty_i;
    inv_b     = 1'b0;
    tgt_way   = f_way;
    wb_set    = 1'b0;
    wb_addr_d = evict_addr_i;
    wb_data_d = evict_data_i;
    if (evict_valid_i) begin
      if (allow) begin
        wr_en = 1'b1;
        if (|match) begin
          tgt_way  = m_way;
          wr_dirty = evict_dirty_i | (|(match & e_dirty));
        end else if (!(|free)) begin
          tgt_way   = v_way;
          wb_set    = e_dirty[v_way];
          wb_addr_d = {e_tags[v_way], e_set};
          wb_data_d = v_rdata;
        end
      end else begin
        inv_b  = |match;
        wb_set = evict_dirty_i | (|(match & e_dirty));
      end
    end
  end

  l2v_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .p_set_i(p_set), .p_tag_i(p_tag), .p_hit_o(p_hit), .p_dirty_o(p_dirty), .p_instr_o(p_instr),
    .e_set_i(e_set), .e_tag_i(e_tag), .e_hit_o(e_hit), .e_valid_o(e_valid), .e_dirty_o(e_dirty),
    .e_tags_o(e_tags),
    .inv_a_en_i(p_hit_any), .inv_a_set_i(p_set), .inv_a_way_i(p_way),
    .inv_b_en_i(inv_b), .inv_b_set_i(e_set), .inv_b_way_i(m_way),
    .wr_en_i(wr_en), .wr_set_i(e_set), .wr_way_i(tgt_way), .wr_tag_i(e_tag),
    .wr_dirty_i(wr_dirty), .wr_instr_i(evict_instr_i)
  );

  l2v_data_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
    .clk_i,
    .a_set_i(p_set), .a_way_i(p_way), .a_data_o(p_rdata),
    .b_set_i(e_set), .b_way_i(v_way), .b_data_o(v_rdata),
    .wr_en_i(wr_en), .wr_set_i(e_set), .wr_way_i(tgt_way), .wr_data_i(evict_data_i)
  );

  l2v_plru #(.SETS(SETS)) u_plru (
    .clk_i, .rst_ni,
    .q_set_i(e_set), .victim_o(v_way),
    .touch_en_i(wr_en), .touch_set_i(e_set), .touch_way_i(tgt_way)
  );

  // two-stage probe response
  logic s1_valid, s1_hit, s1_dirty, s1_instr;
  logic [LINE_W-1:0] s1_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0; s1_hit <= 1'b0; s1_dirty <= 1'b0; s1_instr <= 1'b0; s1_data <= '0;
      resp_valid_o <= 1'b0; resp_hit_o <= 1'b0; resp_dirty_o <= 1'b0; resp_instr_o <= 1'b0;
      resp_data_o <= '0;
      wb_valid_o <= 1'b0; wb_addr_o <= '0; wb_data_o <= '0;
    end else begin
      s1_valid     <= probe_valid_i;
      s1_hit       <= p_hit_any;
      s1_dirty     <= p_hit_any && (|(p_hit & p_dirty));
      s1_instr     <= p_hit_any && (|(p_hit & p_instr));
      s1_data      <= p_hit_any ? p_rdata : '0;
      resp_valid_o <= s1_valid;
      resp_hit_o   <= s1_hit;
      resp_dirty_o <= s1_dirty;
      resp_instr_o <= s1_instr;
      resp_data_o  <= s1_data;
      wb_valid_o   <= wb_set;
      wb_addr_o    <= wb_addr_d;
      wb_data_o    <= wb_data_d;
    end
  end

  assert_resp_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_i |=> ##1 resp_valid_o);
  assert_miss_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> (!resp_dirty_o && !resp_instr_o));
  assert_filter_leak_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && !allow && evict_dirty_i) |=>
      (wb_valid_o && wb_addr_o == $past(evict_addr_i) && wb_data_o == $past(evict_data_i)));
  assert_wb_origin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(evict_valid_i));
endmodule

// File: tb/l2_victim_cache_tb.sv
module l2_victim_cache_tb;
  localparam int LA_W = 27;
  localparam int LW   = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b11;
  logic evict_valid_i = 1'b0, evict_dirty_i = 1'b0, evict_instr_i = 1'b0;
  logic [LA_W-1:0] evict_addr_i = '0, probe_addr_i = '0;
  logic [LW-1:0] evict_data_i = '0;
  logic probe_valid_i = 1'b0;
  logic resp_valid_o, resp_hit_o, resp_dirty_o, resp_instr_o, wb_valid_o;
  logic [LW-1:0] resp_data_o, wb_data_o;
  logic [LA_W-1:0] wb_addr_o;

  always #2 clk = ~clk;  // 250 MHz

  l2_victim_cache u_dut (
    .clk_i(clk), .rst_ni, .mode_i,
    .evict_valid_i, .evict_addr_i, .evict_data_i, .evict_dirty_i, .evict_instr_i,
    .probe_valid_i, .probe_addr_i,
    .resp_valid_o, .resp_hit_o, .resp_data_o, .resp_dirty_o, .resp_instr_o,
    .wb_valid_o, .wb_addr_o, .wb_data_o
  );

  int n_run = 0, n_fail = 0;

  function automatic logic [LW-1:0] line_of(logic [LA_W-1:0] a, logic [4:0] ver);
    return {8{ver, a}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // observed results of one step
  logic o_wb, o_early, o_rv, o_hit, o_dirty, o_instr;
  logic [LA_W-1:0] o_wba;
  logic [LW-1:0] o_wbd, o_rd;

  task automatic step(input logic pv, input logic [LA_W-1:0] pa,
                      input logic ev, input logic [LA_W-1:0] ea, input logic [LW-1:0] ed,
                      input logic edirty, input logic einstr, input logic [1:0] md);
    @(negedge clk);
    probe_valid_i = pv; probe_addr_i = pa;
    evict_valid_i = ev; evict_addr_i = ea; evict_data_i = ed;
    evict_dirty_i = edirty; evict_instr_i = einstr; mode_i = md;
    @(negedge clk);
    o_wb = wb_valid_o; o_wba = wb_addr_o; o_wbd = wb_data_o; o_early = resp_valid_o;
    probe_valid_i = 1'b0; evict_valid_i = 1'b0;
    @(negedge clk);
    o_rv = resp_valid_o; o_hit = resp_hit_o; o_rd = resp_data_o;
    o_dirty = resp_dirty_o; o_instr = resp_instr_o;
  endtask

  typedef struct packed {
    logic            prb;
    logic [LA_W-1:0] addr;
    logic            dirty;
    logic            instr;
    logic [1:0]      mode;
    logic            ehit;
    logic            edirty;
    logic            einstr;
    logic            ewb;
    logic [LA_W-1:0] ewb_addr;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R6/R7: fill set 5 with tags 1..4
    '{1'b0, 27'h045, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b0, 27'h085, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b0, 27'h0C5, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b0, 27'h105, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    // R7/R8: way 0 (dirty) replaced and written back, then way 2 (clean) silently
    '{1'b0, 27'h145, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 27'h045},
    '{1'b0, 27'h185, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b1, 27'h0C5, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b1, 27'h085, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b1, 27'h085, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},  // R3
    '{1'b1, 27'h105, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 27'h0},
    '{1'b1, 27'h045, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    // R5: mode filter on set 9
    '{1'b0, 27'h049, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b1, 27'h049, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b0, 27'h049, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 27'h049},
    '{1'b1, 27'h049, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b0, 27'h049, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 27'h049},
    '{1'b0, 27'h049, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0},
    '{1'b1, 27'h049, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 27'h0},
    '{1'b0, 27'h089, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 27'h089},
    '{1'b1, 27'h089, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0}
  };

  localparam logic [LA_W-1:0] X_A = 27'h0_0407;  // set 7
  localparam logic [LA_W-1:0] Y_A = 27'h0_0808;  // set 8

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resp_valid_o == 1'b0, "R1 resp_valid in reset", LW'(resp_valid_o), '0);
    check(wb_valid_o == 1'b0, "R1 wb_valid in reset", LW'(wb_valid_o), '0);
    rst_ni = 1'b1;
    step(1'b1, 27'h045, 1'b0, '0, '0, 1'b0, 1'b0, 2'b11);
    check(o_rv && !o_hit, "R1 probe after reset misses", LW'({o_rv, o_hit}), LW'(2'b10));

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      if (v.prb) begin
        step(1'b1, v.addr, 1'b0, '0, '0, 1'b0, 1'b0, v.mode);
        check(!o_early, $sformatf("R2 vec %0d early resp", i), LW'(o_early), '0);
        check(o_rv, $sformatf("R2 vec %0d resp_valid", i), LW'(o_rv), LW'(1));
        check(o_hit == v.ehit, $sformatf("R3/R5/R7 vec %0d hit", i), LW'(o_hit), LW'(v.ehit));
        if (v.ehit) begin
          check(o_rd == line_of(v.addr, 5'd0), $sformatf("R2 vec %0d data", i), o_rd,
                line_of(v.addr, 5'd0));
          check({o_dirty, o_instr} == {v.edirty, v.einstr},
                $sformatf("R2 vec %0d dirty/instr", i), LW'({o_dirty, o_instr}),
                LW'({v.edirty, v.einstr}));
        end else begin
          check({o_dirty, o_instr} == 2'b00, $sformatf("R4 vec %0d miss flags", i),
                LW'({o_dirty, o_instr}), '0);
        end
        check(!o_wb, $sformatf("R8 vec %0d no wb on probe", i), LW'(o_wb), '0);
      end else begin
        step(1'b0, '0, 1'b1, v.addr, line_of(v.addr, 5'd0), v.dirty, v.instr, v.mode);
        check(o_wb == v.ewb, $sformatf("R5/R8 vec %0d wb_valid", i), LW'(o_wb), LW'(v.ewb));
        if (v.ewb) begin
          check(o_wba == v.ewb_addr, $sformatf("R5/R8 vec %0d wb_addr", i), LW'(o_wba),
                LW'(v.ewb_addr));
          check(o_wbd == line_of(v.ewb_addr, 5'd0), $sformatf("R5/R8 vec %0d wb_data", i),
                o_wbd, line_of(v.ewb_addr, 5'd0));
        end
      end
    end

    // R9: probe and eviction to one address in the same cycle
    step(1'b0, '0, 1'b1, X_A, line_of(X_A, 5'd1), 1'b1, 1'b0, 2'b11);
    step(1'b1, X_A, 1'b1, X_A, line_of(X_A, 5'd2), 1'b0, 1'b0, 2'b11);
    check(o_hit && o_rd == line_of(X_A, 5'd1), "R9 probe gets old copy", o_rd, line_of(X_A, 5'd1));
    check(o_dirty, "R9 old copy dirty", LW'(o_dirty), LW'(1));
    check(!o_wb, "R9 no write-back", LW'(o_wb), '0);
    step(1'b1, X_A, 1'b0, '0, '0, 1'b0, 1'b0, 2'b11);
    check(o_hit && o_rd == line_of(X_A, 5'd2), "R9 new copy held", o_rd, line_of(X_A, 5'd2));
    check(!o_dirty, "R9 new copy clean", LW'(o_dirty), '0);
    step(1'b1, X_A, 1'b0, '0, '0, 1'b0, 1'b0, 2'b11);
    check(!o_hit, "R9 single copy only", LW'(o_hit), '0);

    // R10: eviction over a resident line
    step(1'b0, '0, 1'b1, Y_A, line_of(Y_A, 5'd1), 1'b1, 1'b0, 2'b11);
    step(1'b0, '0, 1'b1, Y_A, line_of(Y_A, 5'd3), 1'b0, 1'b0, 2'b11);
    check(!o_wb, "R10 no write-back on overwrite", LW'(o_wb), '0);
    step(1'b1, Y_A, 1'b0, '0, '0, 1'b0, 1'b0, 2'b11);
    check(o_hit && o_rd == line_of(Y_A, 5'd3), "R10 data replaced", o_rd, line_of(Y_A, 5'd3));
    check(o_dirty, "R10 dirty kept", LW'(o_dirty), LW'(1));
    step(1'b1, Y_A, 1'b0, '0, '0, 1'b0, 1'b0, 2'b11);
    check(!o_hit, "R10 one way only", LW'(o_hit), '0);

    // R1: reset in mid-run clears resident lines (27'h145 was held)
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(!resp_valid_o && !wb_valid_o, "R1 outputs cleared", LW'({resp_valid_o, wb_valid_o}), '0);
    rst_ni = 1'b1;
    step(1'b1, 27'h145, 1'b0, '0, '0, 1'b0, 1'b0, 2'b11);
    check(o_rv && !o_hit, "R1 line lost at reset", LW'({o_rv, o_hit}), LW'(2'b10));

    finish_run();
  end
endmodule